// File: doc/BRIEF.md
# NAND Parameter Page Copy Validator

This block watches the byte stream that comes back when a NAND device returns its parameter page, and picks out the first trustworthy copy. The device sends the page several times in a row. Each copy is 256 bytes long. A copy is trusted when two tests both pass. First, at least two of its four leading identification bytes are correct. Second, a 16-bit checksum over its body equals the checksum stored at the end of the copy. The block examines at most three copies. It accepts the first one that passes and reports failure if none does.

A pulse on `start` opens a new search. Bytes arrive over a valid/ready handshake. While the search runs, the block decodes the fields that a controller needs before it can address the array: the LUN count and the address-cycle byte. The address-cycle byte splits into a column-cycle count and a row-cycle count. These fields are published only from the accepted copy. Once a verdict is reached, the block stops taking bytes and holds its result until the next `start`.

Top module: `pp_param_validator`

## Requirements
- R1: After reset, `in_ready`, `found` and `fail` are all low, and the decoded fields read zero.
- R2: The checksum register is seeded with 0x4F4E at the first byte of every copy. For each of bytes 0 to 253, the byte is XORed into bits 15:8 of the register. The register is then shifted left 8 times, MSB first, and XORed with 0x8005 whenever the bit shifted out was 1.
- R3: Bytes 254 (low) and 255 (high) of a copy hold the stored checksum. A copy passes the checksum test only when the stored value equals the computed one, so swapping the two bytes makes the test fail.
- R4: Bytes 0 to 3 of a copy are compared with the ASCII characters 'O', 'N', 'F', 'I' at the same positions. The identification test passes when two or more positions match.
- R5: Copies are examined in arrival order, up to three of them. The first copy that passes both tests is accepted, `found` goes high, and `copy_idx` gives its number (0, 1 or 2).
- R6: When three copies have been rejected, `fail` goes high and `found` stays low.
- R7: `lun_count` is byte 100 of the accepted copy. The address-cycle byte is byte 101. Its bits 7:4 appear on `col_cycles` and its bits 3:0 on `row_cycles`. Values in rejected copies never reach these outputs.
- R8: A byte is taken only in a cycle where both `in_valid` and `in_ready` are high. Idle cycles with arbitrary data on `in_data` change nothing.
- R9: Once `found` or `fail` is high, `in_ready` is low and every result output holds until `start`. A `start` pulse, even in the middle of a copy, clears the results and begins a fresh search at copy 0, byte 0.
- R10: `found` or `fail` rises in the cycle right after the clock edge that takes byte 255 of the deciding copy, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle pulse that begins a new search |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | 8 | Parameter page byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| found | output | 1 | A copy passed both tests |
| fail | output | 1 | All copies were rejected |
| copy_idx | output | 2 | Number of the accepted copy |
| lun_count | output | 8 | LUN count from the accepted copy |
| col_cycles | output | 4 | Column address cycle count |
| row_cycles | output | 4 | Row address cycle count |

## Verification
Every verdict and every decoded field is registered once. They are therefore due at the falling edge that follows the rising edge that takes byte 255 of the deciding copy. The bench drives on falling edges and checks at the next falling edge. In one run it also confirms that `found` is still low while that last byte is being driven. A `start` pulse takes effect at the next rising edge, so its cleared state is checked one falling edge later. Before each byte is driven, the bench checks that `in_ready` is high. That check shows that acceptance stops exactly when a verdict is registered.

// File: rtl/pp_pkg.sv
package pp_pkg;

    // identification text expected at the head of each copy, first byte in the top lane
    localparam logic [31:0] ID_TEXT    = "ONFI";
    localparam int          ID_LEN     = 4;
    localparam int          ID_MIN_HIT = 2;

    localparam logic [15:0] SUM_SEED = 16'h4F4E;
    localparam logic [15:0] SUM_POLY = 16'h8005;

endpackage

// File: rtl/pp_crc_step.sv
// One byte of the MSB-first checksum, unrolled into eight shift stages.
module pp_crc_step #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = pp_pkg::SUM_POLY
) (
    input  logic [W-1:0] crc_in,
    input  logic [7:0]   byte_in,
    output logic [W-1:0] crc_out
);
    localparam int STAGES = 8;

    logic [W-1:0] chain [0:STAGES];

    assign chain[0] = crc_in ^ {byte_in, {(W-8){1'b0}}};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        assign chain[g+1] = chain[g][W-1] ? ((chain[g] << 1) ^ POLY)
                                          : (chain[g] << 1);
    end

    assign crc_out = chain[STAGES];
endmodule

// File: rtl/pp_sig_match.sv
// Flags a byte that equals the identification character expected at its position.
module pp_sig_match #(
    parameter int IW = 8
) (
    input  logic [IW-1:0] idx,
    input  logic [7:0]    data,
    output logic          hit
);
    import pp_pkg::*;

    logic [ID_LEN-1:0] pos_hit;

    for (genvar g = 0; g < ID_LEN; g++) begin : g_pos
        assign pos_hit[g] = (idx == IW'(g)) &&
                            (data == ID_TEXT[8*(ID_LEN-1-g) +: 8]);
    end

    assign hit = |pos_hit;
endmodule

// File: rtl/pp_field_capture.sv
// Shadows the decoded fields of the copy in flight, publishes them on commit.
module pp_field_capture #(
    parameter int IW       = 8,
    parameter int LUN_OFS  = 100,
    parameter int ADDR_OFS = 101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          take,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    data,
    input  logic          commit,
    output logic [7:0]    lun_count,
    output logic [3:0]    col_cycles,
    output logic [3:0]    row_cycles
);
    typedef struct packed {
        logic [7:0] lun_sh;
        logic [7:0] adr_sh;
        logic [7:0] lun;
        logic [7:0] adr;
    } fc_t;

    fc_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else begin
            if (take && idx == IW'(LUN_OFS))  d.lun_sh = data;
            if (take && idx == IW'(ADDR_OFS)) d.adr_sh = data;
            if (commit) begin
                d.lun = q.lun_sh;
                d.adr = q.adr_sh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lun_count  = q.lun;
    assign col_cycles = q.adr[7:4];
    assign row_cycles = q.adr[3:0];

    // R7: published fields move only on a commit or a clear
    a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !clear) |=> ($stable(lun_count) && $stable(col_cycles) && $stable(row_cycles)));
endmodule

// File: rtl/pp_param_validator.sv
module pp_param_validator #(
    parameter int          COPY_BYTES = 256,
    parameter int          MAX_COPIES = 3,
    parameter int          LUN_OFS    = 100,
    parameter int          ADDR_OFS   = 101,
    parameter logic [15:0] SEED       = pp_pkg::SUM_SEED,
    parameter logic [15:0] POLY       = pp_pkg::SUM_POLY,
    localparam int         CW         = (MAX_COPIES > 1) ? $clog2(MAX_COPIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    output logic          found,
    output logic          fail,
    output logic [CW-1:0] copy_idx,
    output logic [7:0]    lun_count,
    output logic [3:0]    col_cycles,
    output logic [3:0]    row_cycles
);
    import pp_pkg::*;

    localparam int IW       = $clog2(COPY_BYTES);
    localparam int SUM_SPAN = COPY_BYTES - 2;
    localparam int LAST     = COPY_BYTES - 1;
    localparam int HW       = $clog2(ID_LEN + 1);

    typedef struct packed {
        logic          busy;
        logic          found;
        logic          fail;
        logic [CW-1:0] copy;
        logic [IW-1:0] idx;
        logic [15:0]   crc;
        logic [HW-1:0] hits;
        logic [7:0]    sum_lo;
    } st_t;

    st_t         q, d;
    logic        hs;
    logic        at_last;
    logic        pass;
    logic        commit;
    logic        sig_hit;
    logic [15:0] crc_next;

    pp_crc_step #(.W(16), .POLY(POLY)) u_crc (
        .crc_in  (q.crc),
        .byte_in (in_data),
        .crc_out (crc_next)
    );

    pp_sig_match #(.IW(IW)) u_sig (
        .idx  (q.idx),
        .data (in_data),
        .hit  (sig_hit)
    );

    pp_field_capture #(.IW(IW), .LUN_OFS(LUN_OFS), .ADDR_OFS(ADDR_OFS)) u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .take       (hs),
        .idx        (q.idx),
        .data       (in_data),
        .commit     (commit),
        .lun_count  (lun_count),
        .col_cycles (col_cycles),
        .row_cycles (row_cycles)
    );

    assign in_ready = q.busy;
    assign hs       = in_valid && q.busy;
    assign at_last  = (q.idx == IW'(LAST));
    assign pass     = (q.hits >= HW'(ID_MIN_HIT)) && ({in_data, q.sum_lo} == q.crc);
    assign commit   = hs && at_last && pass && !start;

    always_comb begin
        d = q;
        if (start) begin
            d.busy  = 1'b1;
            d.found = 1'b0;
            d.fail  = 1'b0;
            d.copy  = '0;
            d.idx   = '0;
            d.crc   = SEED;
            d.hits  = '0;
        end else if (hs) begin
            if (q.idx < IW'(SUM_SPAN)) d.crc = crc_next;
            if (sig_hit) d.hits = q.hits + HW'(1);
            if (q.idx == IW'(SUM_SPAN)) d.sum_lo = in_data;
            if (at_last) begin
                if (pass) begin
                    d.busy  = 1'b0;
                    d.found = 1'b1;
                end else if (q.copy == CW'(MAX_COPIES - 1)) begin
                    d.busy = 1'b0;
                    d.fail = 1'b1;
                end else begin
                    d.copy = q.copy + CW'(1);
                    d.idx  = '0;
                    d.crc  = SEED;
                    d.hits = '0;
                end
            end else begin
                d.idx = q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign found    = q.found;
    assign fail     = q.fail;
    assign copy_idx = q.copy;

    // R5/R6: the two verdicts never coexist
    a_r6_verdict_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && fail));
    // R9: no byte is taken once a verdict stands
    a_r9_no_take_after: assert property (@(posedge clk) disable iff (!rst_n)
        (found || fail) |-> !in_ready);
    // R9: a verdict persists until the next start
    a_r9_verdict_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((found || fail) && !start) |=> (found || fail));
    // R5: copy number stays inside the examined range
    a_r5_copy_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.copy <= CW'(MAX_COPIES - 1));
    // R2: every copy begins from the seed value
    a_r2_seed_at_head: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.idx == '0) |-> (q.crc == SEED));
    // R10: a verdict rises only after the final byte of a copy was taken
    a_r10_rise_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(found) || $rose(fail)) |-> $past(hs && at_last));
endmodule

// File: tb/tb_pp_param_validator.sv
module tb_pp_param_validator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, found, fail;
    logic [1:0] copy_idx;
    logic [7:0] lun_count;
    logic [3:0] col_cycles, row_cycles;

    int tests = 0;
    int fails = 0;
    int ready_err = 0;
    int gap = 0;
    logic [7:0] bank [3][256];

    always #4 clk = ~clk;

    pp_param_validator dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .found(found), .fail(fail), .copy_idx(copy_idx),
        .lun_count(lun_count), .col_cycles(col_cycles), .row_cycles(row_cycles)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int c);
        logic [15:0] r = 16'h4F4E;
        for (int i = 0; i < 254; i++) begin
            r ^= {bank[c][i], 8'h00};
            for (int b = 0; b < 8; b++) r = r[15] ? ((r << 1) ^ 16'h8005) : (r << 1);
        end
        return r;
    endfunction

    // mode 0: good checksum, 1: body corrupted after checksum, 2: checksum bytes swapped
    task automatic make_copy(input int c, input logic [7:0] lun, input logic [7:0] adr,
                             input int mask, input int mode);
        logic [15:0] s;
        logic [7:0]  idtxt [4];
        idtxt[0] = "O"; idtxt[1] = "N"; idtxt[2] = "F"; idtxt[3] = "I";
        for (int i = 0; i < 256; i++) bank[c][i] = 8'(i * 13 + c * 29 + 5);
        for (int p = 0; p < 4; p++) bank[c][p] = mask[p] ? idtxt[p] : (idtxt[p] ^ 8'h20);
        bank[c][100] = lun;
        bank[c][101] = adr;
        s = ref_crc(c);
        while (mode == 2 && s[7:0] == s[15:8]) begin
            bank[c][60] ^= 8'h01;
            s = ref_crc(c);
        end
        bank[c][254] = (mode == 2) ? s[15:8] : s[7:0];
        bank[c][255] = (mode == 2) ? s[7:0] : s[15:8];
        if (mode == 1) bank[c][50] ^= 8'h01;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1; in_valid = 1'b0;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        if (gap != 0) begin
            @(negedge clk); in_valid = 1'b0; in_data = 8'h4F;
        end
        @(negedge clk);
        in_valid = 1'b1; in_data = v;
        if (!in_ready) ready_err++;
        @(posedge clk);
    endtask

    task automatic run_copies(input int n);
        pulse_start();
        for (int c = 0; c < n; c++)
            for (int i = 0; i < 256; i++) send_byte(bank[c][i]);
        @(negedge clk); in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "in_ready", in_ready, 0);
        check("R1", "found", found, 0);
        check("R1", "fail", fail, 0);
        check("R1", "lun_count", lun_count, 0);
        rst_n = 1'b1;

        // R5 R7 R10: first copy good, verdict timing around the last byte
        make_copy(0, 8'h02, 8'h53, 15, 0);
        pulse_start();
        for (int i = 0; i < 255; i++) send_byte(bank[0][i]);
        @(negedge clk); in_valid = 1'b1; in_data = bank[0][255];
        check("R10", "found before last edge", found, 0);
        @(posedge clk);
        @(negedge clk); in_valid = 1'b0;
        check("R10", "found after last edge", found, 1);
        check("R5", "copy_idx", copy_idx, 0);
        check("R7", "lun_count", lun_count, 8'h02);
        check("R7", "col_cycles", col_cycles, 4'h5);
        check("R7", "row_cycles", row_cycles, 4'h3);

        // R9: offered bytes after the verdict are refused, results hold
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); in_valid = 1'b1; in_data = 8'(k);
            check("R9", "in_ready after verdict", in_ready, 0);
        end
        @(negedge clk); in_valid = 1'b0;
        check("R9", "found held", found, 1);
        check("R9", "lun held", lun_count, 8'h02);
        pulse_start();
        check("R9", "found cleared by start", found, 0);
        check("R9", "fields cleared by start", {lun_count, col_cycles, row_cycles}, 0);
        check("R9", "in_ready after start", in_ready, 1);

        // R3 R2: swapped checksum rejected, next copy reseeded and accepted
        make_copy(0, 8'h07, 8'h77, 15, 2);
        make_copy(1, 8'h04, 8'h25, 15, 0);
        run_copies(2);
        check("R3", "found", found, 1);
        check("R2", "copy_idx", copy_idx, 1);
        check("R7", "lun from accepted copy", lun_count, 8'h04);
        check("R7", "col/row", {col_cycles, row_cycles}, 8'h25);

        // R6: three bad copies
        for (int c = 0; c < 3; c++) make_copy(c, 8'h09, 8'h99, 15, 1);
        run_copies(3);
        check("R6", "fail", fail, 1);
        check("R6", "found", found, 0);
        check("R7", "fields untouched on fail", lun_count, 0);

        // R5 R7: only the third copy good
        make_copy(0, 8'h01, 8'h11, 15, 1);
        make_copy(1, 8'h01, 8'h11, 15, 1);
        make_copy(2, 8'h08, 8'hA4, 15, 0);
        run_copies(3);
        check("R5", "found third", found, 1);
        check("R5", "copy_idx", copy_idx, 2);
        check("R7", "lun", lun_count, 8'h08);
        check("R7", "col", col_cycles, 4'hA);
        check("R7", "row", row_cycles, 4'h4);

        // R8: idle cycles carrying junk between every byte
        gap = 1;
        make_copy(0, 8'h03, 8'h32, 15, 0);
        run_copies(1);
        gap = 0;
        check("R8", "found with gaps", found, 1);
        check("R8", "lun with gaps", lun_count, 8'h03);
        check("R8", "col/row with gaps", {col_cycles, row_cycles}, 8'h32);

        // R4: every pattern of matching identification positions
        for (int m = 0; m < 16; m++) begin
            int pc;
            pc = $countones(4'(m));
            for (int c = 0; c < 3; c++) make_copy(c, 8'(m), 8'(m * 17), m, 0);
            run_copies(pc >= 2 ? 1 : 3);
            check("R4", $sformatf("found mask %0d", m), found, (pc >= 2) ? 1 : 0);
            check("R4", $sformatf("fail mask %0d", m), fail, (pc >= 2) ? 0 : 1);
            if (pc >= 2) check("R4", $sformatf("lun mask %0d", m), lun_count, 8'(m));
        end

        // R9: start in the middle of a copy restarts at copy 0 byte 0
        make_copy(0, 8'h06, 8'h61, 15, 0);
        pulse_start();
        for (int i = 0; i < 100; i++) send_byte(bank[0][i + 10]);
        run_copies(1);
        check("R9", "found after restart", found, 1);
        check("R9", "copy_idx after restart", copy_idx, 0);
        check("R9", "lun after restart", lun_count, 8'h06);

        check("R8", "in_ready high for every driven byte", ready_err, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule